// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block owns the operating mode of a CAN protocol controller. Host software writes a 3-bit mode field. The controller turns that request into a registered current mode and a set of per-function enables. Those enables gate the transmitter, the receiver, the error counters and configuration writes. Other enables select internal loopback or silent bus operation, and tell the receiver to drop frames that contain errors.

Most mode changes take effect on the clock edge after the write. A request for sleep is held as pending while any of these is true: a transmission is running, the transmit queue is not empty, or another node is using the bus. The change to sleep happens once the transmission is over and the bus is idle, or once an inter-frame gap is seen. While the controller is asleep, wake-up can be armed. When it is armed, a dominant level reported by the low-power bus detector moves the controller into monitor mode and raises a one-cycle wake event.

Top module: `can_mode_ctrl`

## Requirements
- R1: The request field decodes as 000 normal, 001 loopback, 010 monitor, 011 sleep, and 1xx initialization. `cur_mode` reports 000, 001, 010, 011 and 100 for these modes. A write of any mode other than sleep is shown on `cur_mode` after the next rising clock edge.
- R2: While reset is asserted, and after it is released, the controller is in initialization mode (`cur_mode` = 100) until a write arrives.
- R3: In initialization mode the values are `tx_en`=0, `rx_en`=0, `err_cnt_run`=0 and `err_cnt_clr`=1. `core_rst` pulses high for exactly one cycle each time the mode changes into initialization from another mode.
- R4: `cfg_wr_en` is 1 in initialization mode and 0 in every other mode.
- R5: Monitor mode gives `bus_drive_en`=0, `tx_en`=0, `rx_en`=1, `err_cnt_run`=0, `err_cnt_clr`=1 and `drop_err_frame`=1.
- R6: Loopback mode gives `loop_sel`=1, `bus_drive_en`=0, `tx_en`=1, `rx_en`=1 and `err_cnt_run`=1. Normal mode gives `bus_drive_en`=1, `tx_en`=1, `rx_en`=1, `err_cnt_run`=1 and `loop_sel`=0.
- R7: Sleep is entered only on a clock edge where three things hold: `txq_empty`=1, `tx_active`=0, and either `bus_idle` or `ifs_seen` is 1. Until that edge, `cur_mode` keeps showing the previous mode and `sleep_pend` is 1.
- R8: In sleep mode every enable output and `err_cnt_clr` is 0, and `sleep_pend` is 0.
- R9: In sleep mode, if `wake_en`=1 and `lp_dominant`=1 and no write occurs, the controller enters monitor mode at the next edge and `wake_irq` is high for that one cycle. With `wake_en`=0, `lp_dominant` has no effect.
- R10: A write of any mode other than sleep leaves sleep and cancels a pending sleep request at the next edge. Such a write takes priority over a wake-up in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Strobe: `mode_req` is written this cycle |
| mode_req | input | 3 | Requested mode field |
| wake_en | input | 1 | Arms automatic wake-up from sleep |
| lp_dominant | input | 1 | Low-power detector sees a dominant bus level |
| tx_active | input | 1 | A transmission is in progress |
| bus_idle | input | 1 | Bus is idle |
| ifs_seen | input | 1 | Inter-frame gap detected |
| txq_empty | input | 1 | Transmit queue is empty |
| cur_mode | output | 3 | Current mode (000 normal, 001 loopback, 010 monitor, 011 sleep, 100 init) |
| tx_en | output | 1 | Transmitter enabled |
| rx_en | output | 1 | Receiver enabled |
| bus_drive_en | output | 1 | Dominant bits may be driven onto the bus |
| loop_sel | output | 1 | Transmit output routed to receiver internally |
| err_cnt_run | output | 1 | Error counters count |
| err_cnt_clr | output | 1 | Error counters held at zero |
| cfg_wr_en | output | 1 | Bit-timing and filter writes allowed |
| drop_err_frame | output | 1 | Receiver discards frames with errors |
| sleep_pend | output | 1 | Sleep requested but not yet entered |
| wake_irq | output | 1 | One-cycle automatic wake-up event |
| core_rst | output | 1 | One-cycle reset to transmitter and receiver on entering init |

## Verification
The bench writes every mode code, including two different 1xx codes. This separates a full decode of the field from a decode of the low bits only, and it checks the complete enable vector in each mode. The sleep gate is tried in several cases:
- a transmission still active;
- a busy bus later released by an inter-frame gap;
- a non-empty transmit queue;
- an idle bus.

Together these show which gating term is honored. Wake-up is tried with the arm bit low and high, and against a write in the same cycle, to confirm which one wins. Leaving sleep into initialization checks that `core_rst` fires on entry from any mode.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_NORM  = 3'b000,
    M_LOOP  = 3'b001,
    M_MON   = 3'b010,
    M_SLEEP = 3'b011,
    M_INIT  = 3'b100
  } mode_e;

  // Upper bit set selects initialization regardless of the low bits.
  function automatic mode_e decode_req(input logic [MODE_W-1:0] f);
    mode_e m;
    if (f[MODE_W-1]) begin
      m = M_INIT;
    end else begin
      case (f[1:0])
        2'b00:   m = M_NORM;
        2'b01:   m = M_LOOP;
        2'b10:   m = M_MON;
        default: m = M_SLEEP;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/can_mode_rst_sync.sv
module can_mode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              wake_en,
  input  logic              lp_dominant,
  input  logic              tx_active,
  input  logic              bus_idle,
  input  logic              ifs_seen,
  input  logic              txq_empty,
  output mode_e             cur_mode,
  output logic              sleep_pend,
  output logic              wake_irq,
  output logic              core_rst
);

  mode_e cur_q, cur_d;
  mode_e req_q, req_d;
  mode_e req_eff;
  logic  wake_q, wake_d;
  logic  crst_q, crst_d;
  logic  sleep_ok;
  logic  auto_wake;
  logic  state_ld;

  // Next-state logic
  always_comb begin
    req_eff   = mode_wr ? decode_req(mode_req) : req_q;
    sleep_ok  = txq_empty && !tx_active && (bus_idle || ifs_seen);
    auto_wake = (cur_q == M_SLEEP) && !mode_wr && wake_en && lp_dominant;
    cur_d     = cur_q;
    req_d     = req_eff;
    wake_d    = 1'b0;
    if (auto_wake) begin
      cur_d  = M_MON;
      req_d  = M_MON;
      wake_d = 1'b1;
    end else if (req_eff == M_SLEEP) begin
      if ((cur_q != M_SLEEP) && sleep_ok) begin
        cur_d = M_SLEEP;
      end
    end else begin
      cur_d = req_eff;
    end
    crst_d   = (cur_d == M_INIT) && (cur_q != M_INIT);
    state_ld = mode_wr || auto_wake || (cur_d != cur_q);
  end

  // State registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= M_INIT;
      req_q <= M_INIT;
    end else if (state_ld) begin
      cur_q <= cur_d;
      req_q <= req_d;
    end
  end

  // Event pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      crst_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
      crst_q <= crst_d;
    end
  end

  assign cur_mode   = cur_q;
  assign sleep_pend = (req_q == M_SLEEP) && (cur_q != M_SLEEP);
  assign wake_irq   = wake_q;
  assign core_rst   = crst_q;

  // R7: sleep is only reached on an edge where the gate was open
  p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == M_SLEEP) && ($past(cur_q) != M_SLEEP)
      |-> $past(txq_empty && !tx_active && (bus_idle || ifs_seen)));

  // R7: while pending and no new write, the shown mode does not move
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_pend) && !$past(mode_wr) && (cur_q != M_SLEEP)
      |-> $stable(cur_q));

  // R9: a wake event always lands in monitor mode, coming from sleep
  p_wake_mon_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (cur_q == M_MON) && ($past(cur_q) == M_SLEEP));

  // R3: the core reset pulse marks a fresh entry into initialization
  p_core_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (cur_q == M_INIT) && ($past(cur_q) != M_INIT));

endmodule

// File: rtl/can_mode_enables.sv
module can_mode_enables
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  output logic  tx_en,
  output logic  rx_en,
  output logic  bus_drive_en,
  output logic  loop_sel,
  output logic  err_cnt_run,
  output logic  err_cnt_clr,
  output logic  cfg_wr_en,
  output logic  drop_err_frame
);

  always_comb begin
    tx_en          = 1'b0;
    rx_en          = 1'b0;
    bus_drive_en   = 1'b0;
    loop_sel       = 1'b0;
    err_cnt_run    = 1'b0;
    err_cnt_clr    = 1'b0;
    cfg_wr_en      = 1'b0;
    drop_err_frame = 1'b0;
    case (mode)
      M_NORM: begin
        tx_en        = 1'b1;
        rx_en        = 1'b1;
        bus_drive_en = 1'b1;
        err_cnt_run  = 1'b1;
      end
      M_LOOP: begin
        tx_en       = 1'b1;
        rx_en       = 1'b1;
        loop_sel    = 1'b1;
        err_cnt_run = 1'b1;
      end
      M_MON: begin
        rx_en          = 1'b1;
        err_cnt_clr    = 1'b1;
        drop_err_frame = 1'b1;
      end
      M_INIT: begin
        err_cnt_clr = 1'b1;
        cfg_wr_en   = 1'b1;
      end
      default: ;
    endcase
  end

  // R5/R6: dominant bits reach the bus only when not looped back and counting
  p_drive_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> !loop_sel && err_cnt_run && !drop_err_frame);

  // R3: counters are never cleared and counting at once
  p_clr_run_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_cnt_clr && err_cnt_run));

  // R4: configuration access and transmitter are mutually exclusive
  p_cfg_no_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> !tx_en && !rx_en);

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              wake_en,
  input  logic              lp_dominant,
  input  logic              tx_active,
  input  logic              bus_idle,
  input  logic              ifs_seen,
  input  logic              txq_empty,
  output logic [MODE_W-1:0] cur_mode,
  output logic              tx_en,
  output logic              rx_en,
  output logic              bus_drive_en,
  output logic              loop_sel,
  output logic              err_cnt_run,
  output logic              err_cnt_clr,
  output logic              cfg_wr_en,
  output logic              drop_err_frame,
  output logic              sleep_pend,
  output logic              wake_irq,
  output logic              core_rst
);

  logic  rst_n_int;
  mode_e mode_now;

  can_mode_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  can_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .mode_wr     (mode_wr),
    .mode_req    (mode_req),
    .wake_en     (wake_en),
    .lp_dominant (lp_dominant),
    .tx_active   (tx_active),
    .bus_idle    (bus_idle),
    .ifs_seen    (ifs_seen),
    .txq_empty   (txq_empty),
    .cur_mode    (mode_now),
    .sleep_pend  (sleep_pend),
    .wake_irq    (wake_irq),
    .core_rst    (core_rst)
  );

  can_mode_enables u_en (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .mode           (mode_now),
    .tx_en          (tx_en),
    .rx_en          (rx_en),
    .bus_drive_en   (bus_drive_en),
    .loop_sel       (loop_sel),
    .err_cnt_run    (err_cnt_run),
    .err_cnt_clr    (err_cnt_clr),
    .cfg_wr_en      (cfg_wr_en),
    .drop_err_frame (drop_err_frame)
  );

  assign cur_mode = mode_now;

endmodule

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [2:0] mode_req;
  logic       wake_en, lp_dominant, tx_active, bus_idle, ifs_seen, txq_empty;
  logic [2:0] cur_mode;
  logic       tx_en, rx_en, bus_drive_en, loop_sel, err_cnt_run, err_cnt_clr;
  logic       cfg_wr_en, drop_err_frame, sleep_pend, wake_irq, core_rst;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] mode;
    logic       pend;
    logic       wake;
    logic       crst;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  can_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_req(mode_req),
    .wake_en(wake_en), .lp_dominant(lp_dominant), .tx_active(tx_active),
    .bus_idle(bus_idle), .ifs_seen(ifs_seen), .txq_empty(txq_empty),
    .cur_mode(cur_mode), .tx_en(tx_en), .rx_en(rx_en),
    .bus_drive_en(bus_drive_en), .loop_sel(loop_sel),
    .err_cnt_run(err_cnt_run), .err_cnt_clr(err_cnt_clr),
    .cfg_wr_en(cfg_wr_en), .drop_err_frame(drop_err_frame),
    .sleep_pend(sleep_pend), .wake_irq(wake_irq), .core_rst(core_rst)
  );

  // Enable vector {tx,rx,drive,loop,run,clr,cfg,drop} from the requirements
  function automatic logic [7:0] en_of(input logic [2:0] m);
    case (m)
      3'b000:  return 8'b1110_1000; // normal R6
      3'b001:  return 8'b1101_1000; // loopback R6
      3'b010:  return 8'b0100_0101; // monitor R5
      3'b100:  return 8'b0000_0110; // init R3 R4
      default: return 8'b0000_0000; // sleep R8
    endcase
  endfunction

  task automatic compare(input exp_t e);
    logic [7:0] en_act;
    en_act = {tx_en, rx_en, bus_drive_en, loop_sel,
              err_cnt_run, err_cnt_clr, cfg_wr_en, drop_err_frame};
    n_vec++;
    if (cur_mode !== e.mode || en_act !== en_of(e.mode) ||
        sleep_pend !== e.pend || wake_irq !== e.wake || core_rst !== e.crst) begin
      n_fail++;
      $display("FAIL %s: mode=%b en=%b pend=%b wake=%b crst=%b exp mode=%b en=%b pend=%b wake=%b crst=%b",
               e.tag, cur_mode, en_act, sleep_pend, wake_irq, core_rst,
               e.mode, en_of(e.mode), e.pend, e.wake, e.crst);
    end
  endtask

  // Monitor: compare queued expectations after each edge settles
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  // Driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic wr, input logic [2:0] req,
                      input logic [2:0] em, input logic ep,
                      input logic ew, input logic ec, input string tag);
    exp_t e;
    @(negedge clk);
    mode_wr  = wr;
    mode_req = req;
    @(posedge clk);
    #1;
    mode_wr = 1'b0;
    e.mode = em; e.pend = ep; e.wake = ew; e.crst = ec; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, exp done=1 act=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; mode_wr = 1'b0; mode_req = 3'b000;
    wake_en = 1'b0; lp_dominant = 1'b0; tx_active = 1'b0;
    bus_idle = 1'b1; ifs_seen = 1'b0; txq_empty = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    r.mode = 3'b100; r.pend = 0; r.wake = 0; r.crst = 0; r.tag = "R2 in reset";
    compare(r);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    r.tag = "R2 after release";
    compare(r);

    step(1, 3'b000, 3'b000, 0, 0, 0, "R1 R6 normal");
    step(1, 3'b001, 3'b001, 0, 0, 0, "R1 R6 loopback");
    step(1, 3'b010, 3'b010, 0, 0, 0, "R1 R5 monitor");
    step(1, 3'b111, 3'b100, 0, 0, 1, "R1 R3 init 111 core_rst");
    step(0, 3'b000, 3'b100, 0, 0, 0, "R3 core_rst one cycle");
    step(1, 3'b101, 3'b100, 0, 0, 0, "R1 R4 init 101 no re-entry");
    step(1, 3'b000, 3'b000, 0, 0, 0, "R4 normal cfg closed");

    tx_active = 1'b1;
    step(1, 3'b011, 3'b000, 1, 0, 0, "R7 deferred by tx");
    tx_active = 1'b0; bus_idle = 1'b0;
    step(0, 3'b000, 3'b000, 1, 0, 0, "R7 deferred by busy bus");
    ifs_seen = 1'b1;
    step(0, 3'b000, 3'b011, 0, 0, 0, "R7 R8 enter at gap");
    ifs_seen = 1'b0; bus_idle = 1'b1;

    lp_dominant = 1'b1;
    step(0, 3'b000, 3'b011, 0, 0, 0, "R9 wake disarmed");
    wake_en = 1'b1;
    step(0, 3'b000, 3'b010, 0, 1, 0, "R9 auto wake to monitor");
    lp_dominant = 1'b0;
    step(0, 3'b000, 3'b010, 0, 0, 0, "R9 wake pulse one cycle");

    txq_empty = 1'b0;
    step(1, 3'b011, 3'b010, 1, 0, 0, "R7 deferred by queue");
    step(1, 3'b001, 3'b001, 0, 0, 0, "R10 pending cancelled");
    txq_empty = 1'b1;
    step(1, 3'b011, 3'b011, 0, 0, 0, "R7 immediate when idle");
    lp_dominant = 1'b1;
    step(1, 3'b000, 3'b000, 0, 0, 0, "R10 write beats wake");
    lp_dominant = 1'b0;
    step(1, 3'b011, 3'b011, 0, 0, 0, "R7 sleep again");
    step(1, 3'b110, 3'b100, 0, 0, 1, "R10 R3 sleep to init");

    @(posedge clk);
    #5;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule